// File: doc/BRIEF.md
# Bus Response and Halt Monitor

This block supervises bus cycles and raises a bus-error strobe whenever the response to a cycle fails to arrive within a programmable number of clocks. An ordinary cycle is closed by the data/size acknowledge. An interrupt-acknowledge cycle may be closed either by that acknowledge or by an autovector response. Cycles that cross from the internal to the external bus are supervised only when a dedicated enable is set, and then only if the CPU started them. Cycles from any other master are never timed, so a separate external monitor has to cover them.

The block also watches the halt line. When the halt-reset enable is set, an asserted halt produces a reset request and sets a sticky cause flag. That flag stays set until a reset from some other source is recorded.

Top module: `bus_resp_monitor`

## Requirements
- R1: The timeout is chosen by `tmo_sel`: 00 gives 64 clocks, 01 gives 32, 10 gives 16 and 11 gives 8. A supervised cycle that gets no response raises `bus_err` on the rising edge that comes that many edges after the edge that sampled `cyc_start`.
- R2: In an ordinary cycle (`cyc_iack`=0), `ack` ends the cycle with no bus error. `avec` has no effect on it, and the timeout still occurs.
- R3: In an interrupt-acknowledge cycle (`cyc_iack`=1), either `ack` or `avec` ends the cycle with no bus error.
- R4: A response sampled on the same edge where the timeout would fire takes priority, so no bus error is raised.
- R5: `bus_err` is high for exactly one clock, and the timed-out cycle is then closed. No further strobe follows until a new cycle starts.
- R6: A cycle with `cyc_ext`=1 is timed only when `ext_mon_en`=1 and `cyc_by_cpu`=1. Otherwise it never raises `bus_err`. Internal cycles (`cyc_ext`=0) are always timed.
- R7: When `halt_mon_en`=1, `halt` sampled high makes `rst_req` high in the following clock and sets `halt_cause`.
- R8: When `halt_mon_en`=0, `halt` leaves `rst_req` low and `halt_cause` unchanged.
- R9: `other_rst` sampled high clears `halt_cause`. If a halt-triggered reset is recorded on the same edge, the halt wins and the flag stays set.
- R10: A `cyc_start` sampled while a cycle is pending restarts the count from zero.
- R11: After reset, `bus_err`, `rst_req` and `halt_cause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse that begins a bus cycle |
| cyc_iack | input | 1 | The starting cycle is an interrupt acknowledge |
| cyc_ext | input | 1 | The starting cycle goes from the internal to the external bus |
| cyc_by_cpu | input | 1 | The starting cycle was issued by the CPU |
| ack | input | 1 | Data/size acknowledge response |
| avec | input | 1 | Autovector response |
| halt | input | 1 | Halt indication |
| tmo_sel | input | 2 | Timeout selection code |
| ext_mon_en | input | 1 | Enables supervision of internal-to-external cycles |
| halt_mon_en | input | 1 | Enables a reset request on halt |
| other_rst | input | 1 | A reset from another source is being recorded |
| bus_err | output | 1 | One-clock bus-error strobe |
| rst_req | output | 1 | Reset request caused by halt |
| halt_cause | output | 1 | Sticky flag: the last reset came from the halt monitor |

## Verification
The hardest case to reach from the ports is the exact boundary edge, where the response and the timeout arrive together. The bench counts rising edges from the one that sampled `cyc_start` and places `ack` or `avec` on edge N, where N is the selected limit. It then repeats with the response one edge later, so both sides of the boundary are tested. Restart while pending is reached by issuing a second `cyc_start` part-way through a cycle and checking that the strobe moves out to the full limit measured from the second start.

// File: rtl/bus_resp_monitor_pkg.sv
// Package: shared constants and the timeout decode for the bus response monitor.
// Assumes the base timeout is a power of two, so each code halves it.
package bus_resp_monitor_pkg;

    localparam int unsigned TMO_BASE = 64;
    localparam int unsigned TMO_CNT_W = $clog2(TMO_BASE + 1);

    // Decode the two-bit timeout code into a clock count (base >> code).
    function automatic logic [TMO_CNT_W-1:0] tmo_limit(input logic [1:0] code);
        logic [TMO_CNT_W-1:0] base_v;
        base_v = TMO_CNT_W'(TMO_BASE);
        return base_v >> code;
    endfunction

endpackage

// File: rtl/bmon_resp_timer.sv
// Module: times one pending bus cycle and strobes bus_err when the response
// is late. Assumes start has already been qualified (only supervised
// cycles arrive). A response on the timeout edge wins over the error.
module bmon_resp_timer #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_iack,
    input  logic             ack,
    input  logic             avec,
    input  logic [CNT_W-1:0] limit,
    output logic             bus_err
);

    logic             pend_q;
    logic             iack_q;
    logic [CNT_W-1:0] cnt_q;
    logic             resp;
    logic             expire;

    // Response that closes the pending cycle, according to its type.
    always_comb begin
        resp   = ack | (iack_q & avec);
        expire = pend_q & ~resp & (cnt_q == limit - CNT_W'(1));
    end

    // Track the pending cycle, count clocks, and fire the error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            iack_q  <= 1'b0;
            cnt_q   <= '0;
            bus_err <= 1'b0;
        end else begin
            bus_err <= expire;
            if (start) begin
                pend_q <= 1'b1;
                iack_q <= start_iack;
                cnt_q  <= '0;
            end else if (pend_q) begin
                if (resp || expire) begin
                    pend_q <= 1'b0;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    // R5: strobe lasts one clock
    p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !bus_err);
    // R5: no error without a pending cycle
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q |=> !bus_err);
    // R4: a response in a pending cycle suppresses the error
    p_resp_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && resp) |=> !bus_err);
    // R1: count never passes the selected limit
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (cnt_q < limit));

endmodule

// File: rtl/bmon_halt_watch.sv
// Module: turns an enabled halt into a reset request and keeps a sticky
// halt-cause flag, which a reset from another source clears.
// Assumes halt and other_rst are synchronous to clk.
module bmon_halt_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic enable,
    input  logic other_rst,
    output logic rst_req,
    output logic cause
);

    logic trig;

    // Qualify halt with its enable.
    always_comb trig = halt & enable;

    // Register the request and update the sticky cause flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            cause   <= 1'b0;
        end else begin
            rst_req <= trig;
            if (trig)
                cause <= 1'b1;
            else if (other_rst)
                cause <= 1'b0;
        end
    end

    // R7: enabled halt gives request and flag
    p_halt_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && enable) |=> (rst_req && cause));
    // R8: disabled halt gives no request
    p_halt_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> !rst_req);
    // R9: other reset clears the flag unless a halt reset coincides
    p_other_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (other_rst && !(halt && enable)) |=> !cause);

endmodule

// File: rtl/bus_resp_monitor.sv
// Module: top of the bus response and halt monitor. Decides which cycles
// are supervised, decodes the timeout, and combines the response timer
// with the halt watcher. Assumes all inputs are synchronous to clk.
module bus_resp_monitor
    import bus_resp_monitor_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_start,
    input  logic       cyc_iack,
    input  logic       cyc_ext,
    input  logic       cyc_by_cpu,
    input  logic       ack,
    input  logic       avec,
    input  logic       halt,
    input  logic [1:0] tmo_sel,
    input  logic       ext_mon_en,
    input  logic       halt_mon_en,
    input  logic       other_rst,
    output logic       bus_err,
    output logic       rst_req,
    output logic       halt_cause
);

    logic                 sup_start;
    logic [TMO_CNT_W-1:0] limit;

    // Supervise internal cycles always; external ones only if enabled and CPU-issued.
    always_comb begin
        sup_start = cyc_start & (~cyc_ext | (ext_mon_en & cyc_by_cpu));
        limit     = tmo_limit(tmo_sel);
    end

    bmon_resp_timer #(.CNT_W(TMO_CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (sup_start),
        .start_iack (cyc_iack),
        .ack        (ack),
        .avec       (avec),
        .limit      (limit),
        .bus_err    (bus_err)
    );

    bmon_halt_watch u_halt (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (halt),
        .enable    (halt_mon_en),
        .other_rst (other_rst),
        .rst_req   (rst_req),
        .cause     (halt_cause)
    );

    // R6: an unsupervised external start never begins a cycle
    p_ext_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && cyc_ext && !(ext_mon_en && cyc_by_cpu)) |-> !sup_start);

endmodule

// File: tb/bus_resp_monitor_test.sv
module bus_resp_monitor_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0, cyc_iack = 1'b0, cyc_ext = 1'b0, cyc_by_cpu = 1'b0;
    logic       ack = 1'b0, avec = 1'b0, halt = 1'b0;
    logic [1:0] tmo_sel = 2'b00;
    logic       ext_mon_en = 1'b0, halt_mon_en = 1'b0, other_rst = 1'b0;
    logic       bus_err, rst_req, halt_cause;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    bus_resp_monitor uut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_iack(cyc_iack),
        .cyc_ext(cyc_ext), .cyc_by_cpu(cyc_by_cpu), .ack(ack), .avec(avec),
        .halt(halt), .tmo_sel(tmo_sel), .ext_mon_en(ext_mon_en),
        .halt_mon_en(halt_mon_en), .other_rst(other_rst),
        .bus_err(bus_err), .rst_req(rst_req), .halt_cause(halt_cause)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Start a cycle, optionally respond on edge resp_at (0 = never), restart on
    // edge restart_at (0 = never). Returns the first edge with bus_err (0 = none)
    // and the number of strobe clocks seen.
    task automatic run_cycle(input logic [1:0] sel, input logic iack, input logic ext,
                             input logic cpu, input int resp_at, input logic use_avec,
                             input int restart_at, output int err_edge, output int err_cnt);
        tmo_sel = sel; cyc_iack = iack; cyc_ext = ext; cyc_by_cpu = cpu;
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        err_edge = 0; err_cnt = 0;
        for (int k = 1; k <= 140; k++) begin
            if (k == resp_at) begin
                if (use_avec) avec = 1'b1; else ack = 1'b1;
            end
            if (k == restart_at) cyc_start = 1'b1;
            @(negedge clk);
            ack = 1'b0; avec = 1'b0; cyc_start = 1'b0;
            if (bus_err) begin
                err_cnt++;
                if (err_edge == 0) err_edge = k;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk); @(negedge clk);
        check("R11 bus_err", bus_err, 0);
        check("R11 rst_req", rst_req, 0);
        check("R11 halt_cause", halt_cause, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_timeouts();
        int e, n;
        for (int s = 0; s < 4; s++) begin
            run_cycle(2'(s), 1'b0, 1'b0, 1'b1, 0, 1'b0, 0, e, n);
            check("R1 timeout edge", e, 64 >> s);
            check("R5 one strobe", n, 1);
        end
    endtask

    task automatic t_normal_resp();
        int e, n;
        run_cycle(2'b10, 1'b0, 1'b0, 1'b1, 5, 1'b0, 0, e, n);
        check("R2 ack closes normal cycle", n, 0);
        run_cycle(2'b10, 1'b0, 1'b0, 1'b1, 5, 1'b1, 0, e, n);
        check("R2 avec ignored in normal cycle", e, 16);
    endtask

    task automatic t_iack();
        int e, n;
        run_cycle(2'b11, 1'b1, 1'b0, 1'b1, 3, 1'b1, 0, e, n);
        check("R3 avec closes iack", n, 0);
        run_cycle(2'b11, 1'b1, 1'b0, 1'b1, 4, 1'b0, 0, e, n);
        check("R3 ack closes iack", n, 0);
    endtask

    task automatic t_boundary();
        int e, n;
        run_cycle(2'b11, 1'b0, 1'b0, 1'b1, 8, 1'b0, 0, e, n);
        check("R4 ack on timeout edge wins", n, 0);
        run_cycle(2'b11, 1'b1, 1'b0, 1'b1, 8, 1'b1, 0, e, n);
        check("R4 avec on timeout edge wins", n, 0);
        run_cycle(2'b11, 1'b0, 1'b0, 1'b1, 9, 1'b0, 0, e, n);
        check("R4 late ack too late", e, 8);
        check("R5 late ack no second strobe", n, 1);
    endtask

    task automatic t_external();
        int e, n;
        ext_mon_en = 1'b0;
        run_cycle(2'b11, 1'b0, 1'b1, 1'b1, 0, 1'b0, 0, e, n);
        check("R6 ext disabled", n, 0);
        ext_mon_en = 1'b1;
        run_cycle(2'b11, 1'b0, 1'b1, 1'b0, 0, 1'b0, 0, e, n);
        check("R6 non-cpu ext untimed", n, 0);
        run_cycle(2'b11, 1'b0, 1'b1, 1'b1, 0, 1'b0, 0, e, n);
        check("R6 cpu ext timed", e, 8);
        ext_mon_en = 1'b0;
        run_cycle(2'b11, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0, e, n);
        check("R6 internal non-cpu timed", e, 8);
    endtask

    task automatic t_restart();
        int e, n;
        run_cycle(2'b10, 1'b0, 1'b0, 1'b1, 0, 1'b0, 10, e, n);
        check("R10 restart moves timeout", e, 26);
        check("R10 single strobe", n, 1);
    endtask

    task automatic t_halt();
        halt_mon_en = 1'b0; halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        check("R8 masked halt no request", rst_req, 0);
        check("R8 masked halt no flag", halt_cause, 0);
        halt_mon_en = 1'b1; halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        check("R7 halt request", rst_req, 1);
        check("R7 halt flag", halt_cause, 1);
        @(negedge clk);
        check("R7 request drops", rst_req, 0);
        halt = 1'b1; other_rst = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        check("R9 halt wins over other reset", halt_cause, 1);
        @(negedge clk);
        other_rst = 1'b0;
        check("R9 other reset clears flag", halt_cause, 0);
        halt_mon_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_timeouts();
        t_normal_resp();
        t_iack();
        t_boundary();
        t_external();
        t_restart();
        t_halt();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule